// File: doc/BRIEF.md
# Post-Transmit Collision Heartbeat Checker

This block watches the end of every frame the transmitter sends. It confirms that the attached transceiver has answered with a collision heartbeat pulse, which is the signal-quality test pulse. A window opens on the end-of-transmit strobe and is measured in network bit times, which arrive as single-cycle ticks. If the collision input is not seen before the window closes, the block emits a collision-error event. The heartbeat test applies only to the attachment-unit port and the general serial port, and only in half-duplex. In full-duplex on those ports the check is not done.

On a twisted-pair port no heartbeat is expected, and a different rule applies. A transmission that ends while the link-integrity logic reports the link as failed produces the same error event, in either duplex mode. The output is a single-cycle event. It feeds the sticky collision-error bit of the status register and, through that bit, the summary error bit. It never drives an interrupt request. Clearing the sticky bit (write-one, resets, stop command) belongs to that register and not to this block.

Top module: `sqe_heartbeat_chk`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, `col_err_evt` is 0.
- R2: On a half-duplex port with `port_sel` 2'b00 (attachment unit) or 2'b01 (serial), a collision input seen at a clock edge after the end-of-transmit strobe and before the 20th bit tick produces no event for that transmission.
- R3: On such a half-duplex port, if the 20th bit tick after the end-of-transmit strobe arrives with no collision seen, `col_err_evt` is 1 in the cycle after the clock edge that samples that tick.
- R4: With `full_duplex` at 1 and `port_sel` 2'b00 or 2'b01, no heartbeat window opens and no event is produced, however many ticks follow.
- R5: With `port_sel[1]` at 1 (twisted pair), an end-of-transmit strobe sampled while `link_fail` is 1 gives `col_err_evt` at 1 in the next cycle, in both half- and full-duplex.
- R6: On a twisted-pair port with `link_fail` at 0, no event is produced and no heartbeat window opens.
- R7: A `tx_start` strobe sampled while a window is pending ends the window without an event.
- R8: Every event is exactly one clock cycle long.
- R9: A new end-of-transmit strobe during a pending window restarts the count from zero, so the event comes 20 ticks after the later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_start | input | 1 | One-cycle strobe: a transmission begins |
| tx_end | input | 1 | One-cycle strobe: a transmission has ended |
| col_in | input | 1 | Collision input from the transceiver |
| bit_tick | input | 1 | One-cycle strobe per network bit time |
| full_duplex | input | 1 | 1 = full-duplex operation |
| port_sel | input | 2 | 00 attachment unit, 01 serial, 1x twisted pair |
| link_fail | input | 1 | 1 = twisted-pair link in the failed state |
| col_err_evt | output | 1 | One-cycle collision-error event to the status register |

## Verification
The heartbeat is placed at bit time 19 and at bit time 21, with the window boundary between them. These two cases separate a window that is correct from one that is one tick too short or too long. Silent runs on both half-duplex ports check that the timer fires. The same runs in full-duplex and on a healthy twisted-pair link check that the port and duplex gating holds it off. A link-fail end of transmit in both duplex modes shows that the twisted-pair rule ignores duplex. Aborted and restarted windows, and two windows in a row, show that the pending state is dropped or reset and that each miss gives one pulse only.

// File: rtl/sqe_pkg.sv
package sqe_pkg;

  typedef enum logic [1:0] {
    PSEL_ATTACH = 2'b00,
    PSEL_SERIAL = 2'b01,
    PSEL_TPAIR  = 2'b10,
    PSEL_TPAIR2 = 2'b11
  } psel_e;

  typedef enum logic {
    HB_IDLE = 1'b0,
    HB_WAIT = 1'b1
  } hb_state_e;

endpackage

// File: rtl/sqe_rst_sync.sv
module sqe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sqe_port_decode.sv
module sqe_port_decode
  import sqe_pkg::*;
(
  input  logic [1:0] port_sel,
  input  logic       full_duplex,
  output logic       hb_enable,
  output logic       tpair_sel
);
  psel_e psel;

  always_comb begin
    psel      = psel_e'(port_sel);
    tpair_sel = 1'b0;
    hb_enable = 1'b0;
    case (psel)
      PSEL_ATTACH, PSEL_SERIAL: hb_enable = !full_duplex;
      default:                  tpair_sel = 1'b1;
    endcase
  end
endmodule

// File: rtl/sqe_window_timer.sv
module sqe_window_timer
  import sqe_pkg::*;
#(
  parameter int unsigned WINDOW_BITS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic end_i,
  input  logic arm_i,
  input  logic start_i,
  input  logic col_i,
  input  logic tick_i,
  output logic pending_o,
  output logic miss_o
);
  localparam int unsigned CNT_W = $clog2(WINDOW_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_BITS - 1);

  hb_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             miss_q, miss_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    miss_d  = 1'b0;
    if (end_i) begin
      state_d = arm_i ? HB_WAIT : HB_IDLE;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (state_q == HB_WAIT) begin
      if (col_i || start_i) begin
        state_d = HB_IDLE;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          state_d = HB_IDLE;
          miss_d  = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HB_IDLE;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pending_o = (state_q == HB_WAIT);
  assign miss_o    = miss_q;

  assert_window_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !end_i && !col_i && !start_i && tick_i && cnt_q == LAST) |=> miss_o);

  assert_heartbeat_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && col_i && !end_i) |=> (!miss_o && !pending_o));

  assert_start_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && start_i && !end_i) |=> (!miss_o && !pending_o));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |=> !miss_o);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && arm_i) |=> (pending_o && !miss_o));
endmodule

// File: rtl/sqe_linkfail_rule.sv
module sqe_linkfail_rule (
  input  logic clk,
  input  logic rst_n,
  input  logic end_i,
  input  logic tpair_i,
  input  logic link_fail_i,
  output logic fail_o
);
  logic fail_q, fail_d;

  always_comb fail_d = end_i && tpair_i && link_fail_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= fail_d;
  end

  assign fail_o = fail_q;

  assert_linkfail_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && tpair_i && link_fail_i) |=> fail_o);

  assert_link_ok_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !link_fail_i) |=> !fail_o);
endmodule

// File: rtl/sqe_heartbeat_chk.sv
module sqe_heartbeat_chk #(
  parameter int unsigned WINDOW_BITS = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_start,
  input  logic       tx_end,
  input  logic       col_in,
  input  logic       bit_tick,
  input  logic       full_duplex,
  input  logic [1:0] port_sel,
  input  logic       link_fail,
  output logic       col_err_evt
);
  logic rst_sync_n;
  logic hb_enable, tpair_sel;
  logic hb_pending, hb_miss, lf_event;

  sqe_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  sqe_port_decode u_dec (
    .port_sel(port_sel), .full_duplex(full_duplex),
    .hb_enable(hb_enable), .tpair_sel(tpair_sel));

  sqe_window_timer #(.WINDOW_BITS(WINDOW_BITS)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .end_i(tx_end), .arm_i(hb_enable),
    .start_i(tx_start), .col_i(col_in), .tick_i(bit_tick),
    .pending_o(hb_pending), .miss_o(hb_miss));

  sqe_linkfail_rule u_lf (
    .clk(clk), .rst_n(rst_sync_n), .end_i(tx_end), .tpair_i(tpair_sel),
    .link_fail_i(link_fail), .fail_o(lf_event));

  assign col_err_evt = hb_miss | lf_event;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |-> !col_err_evt);

  assert_full_duplex_off_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_end && full_duplex) |=> !hb_pending);

  assert_tpair_no_window_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_end && port_sel[1]) |=> !hb_pending);
endmodule

// File: tb/sqe_heartbeat_chk_tb_top.sv
module sqe_heartbeat_chk_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tx_start = 1'b0, tx_end = 1'b0, col_in = 1'b0;
  logic bit_tick = 1'b0, full_duplex = 1'b0, link_fail = 1'b0;
  logic [1:0] port_sel = 2'b00;
  logic err;

  sqe_heartbeat_chk dut_i (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
    .col_in(col_in), .bit_tick(bit_tick), .full_duplex(full_duplex),
    .port_sel(port_sel), .link_fail(link_fail), .col_err_evt(err));

  typedef struct { int at; string req; } exp_t;
  exp_t  expq[$];
  int    cyc = 0;
  int    checks = 0, fails = 0, seen = 0, exp_n = 0, tcount = 0;
  string cur_req = "R1";
  logic  prev_err = 1'b0;
  bit    model_pending = 1'b0, done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected events and compares with the output
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_err && err) begin
        checks++; fails++;
        $display("FAIL R8 event width actual=2+ cycles expected=1 cycle at %0d", cyc);
      end
      if (err) begin
        seen++; checks++;
        if (expq.size() > 0 && expq[0].at == cyc) void'(expq.pop_front());
        else begin
          fails++;
          $display("FAIL %s event at cycle %0d actual=1 expected=0", cur_req, cyc);
        end
      end else if (expq.size() > 0 && expq[0].at <= cyc) begin
        checks++; fails++;
        $display("FAIL %s missing event at cycle %0d actual=0 expected=1",
                 expq[0].req, expq[0].at);
        void'(expq.pop_front());
      end
      prev_err = err;
    end
  end

  task automatic next();
    @(posedge clk); #1;
  endtask

  task automatic push_exp(int at);
    exp_t e; e.at = at; e.req = cur_req;
    expq.push_back(e); exp_n++;
  endtask

  task automatic begin_scn(string req);
    cur_req = req; seen = 0; exp_n = 0;
  endtask

  task automatic end_scn();
    repeat (3) next();
    checks++;
    if (seen != exp_n || expq.size() != 0) begin
      fails++;
      $display("FAIL %s event count actual=%0d expected=%0d", cur_req, seen, exp_n);
    end
    expq.delete();
  endtask

  task automatic pulse_end();
    tx_end = 1'b1;
    if (port_sel[1] && link_fail) push_exp(cyc + 1);
    model_pending = !port_sel[1] && !full_duplex;
    tcount = 0;
    next(); tx_end = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      if (model_pending) begin
        tcount++;
        if (tcount == 20) begin push_exp(cyc + 1); model_pending = 1'b0; end
      end
      next(); bit_tick = 1'b0;
      next();
    end
  endtask

  task automatic pulse_col();
    col_in = 1'b1; model_pending = 1'b0;
    next(); col_in = 1'b0; next();
  endtask

  task automatic pulse_start();
    tx_start = 1'b1; model_pending = 1'b0;
    next(); tx_start = 1'b0; next();
  endtask

  task automatic setup(logic [1:0] p, logic fd, logic lf);
    port_sel = p; full_duplex = fd; link_fail = lf;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) next();
    checks++;
    if (err !== 1'b0) begin fails++; $display("FAIL R1 in reset actual=%b expected=0", err); end
    rst_n = 1'b1;
    repeat (5) next();
    checks++;
    if (err !== 1'b0) begin fails++; $display("FAIL R1 after reset actual=%b expected=0", err); end

    begin_scn("R2"); setup(2'b00, 1'b0, 1'b0);          // heartbeat at bit 19
    pulse_end(); ticks(19); pulse_col(); ticks(6); end_scn();

    begin_scn("R2"); setup(2'b01, 1'b0, 1'b0);          // heartbeat right away
    pulse_end(); pulse_col(); ticks(25); end_scn();

    begin_scn("R3"); setup(2'b00, 1'b0, 1'b0);          // heartbeat at bit 21
    pulse_end(); ticks(21); pulse_col(); ticks(3); end_scn();

    begin_scn("R3"); setup(2'b01, 1'b0, 1'b0);          // no heartbeat, serial
    pulse_end(); ticks(25); end_scn();

    begin_scn("R4"); setup(2'b00, 1'b1, 1'b0);
    pulse_end(); ticks(25); end_scn();

    begin_scn("R4"); setup(2'b01, 1'b1, 1'b1);
    pulse_end(); ticks(25); end_scn();

    begin_scn("R5"); setup(2'b10, 1'b0, 1'b1);          // half duplex
    pulse_end(); ticks(22); end_scn();

    begin_scn("R5"); setup(2'b10, 1'b1, 1'b1);          // full duplex
    pulse_end(); ticks(22); end_scn();

    begin_scn("R6"); setup(2'b10, 1'b0, 1'b0);
    pulse_end(); ticks(25); end_scn();

    begin_scn("R6"); setup(2'b11, 1'b1, 1'b0);
    pulse_end(); ticks(25); end_scn();

    begin_scn("R7"); setup(2'b00, 1'b0, 1'b0);
    pulse_end(); ticks(10); pulse_start(); ticks(15); end_scn();

    begin_scn("R9"); setup(2'b00, 1'b0, 1'b0);
    pulse_end(); ticks(15); pulse_end(); ticks(15); ticks(8); end_scn();

    begin_scn("R8"); setup(2'b01, 1'b0, 1'b0);          // two misses in a row
    pulse_end(); ticks(21); pulse_end(); ticks(21); end_scn();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule